// File: doc/BRIEF.md
# Delay-line calibration sequencer for a DDR PHY

This block is a small register-bus master that brings up the variable delay line of a DDR PHY after its PLL has locked. After a start pulse it runs two calibration passes. Each pass clears the PHY's delay-line control register and then writes a pass-specific go value. It then polls the status register once per microsecond tick until the complete bit appears or the pass's poll budget runs out. Timeouts and lock results are reported on flag outputs, and the sequence always continues.

Once the second pass ends, the block settles a step size. The step size is taken from a ten-bit field of the final status word when that pass completed with its lock bit clear. When that field is zero, or in any other case, the block computes a fallback from the configured DDR clock in MHz: the remainder of one million divided by the speed, times a fixed reciprocal constant, shifted right by 22. The block then reads the channel status register. When that register's bit 1 is clear, the block writes a fine override code and then a coarse override code derived from the step size. A one-cycle done pulse closes the run. The step size and both codes stay on the outputs until the next start.

Top module: `vdl_cal_seq`

## Requirements
- R1: After reset the block is idle: no bus strobe, done and busy low, step size, override codes and all flags zero.
- R2: Each bus request drives exactly one of the write or read strobes. It keeps address, data and strobe unchanged until the cycle in which bus_ready is high, which completes it. Read data is taken in that cycle.
- R3: Pass one writes 0 and then 0x103 to the control register (0x2848). It reads status (0x284C) once at once and then once per tick_us pulse until bit 0 is set, with at most 100 reads in total. p1_timeout is set when all 100 reads see bit 0 clear. p1_lock is set when the completing read has bit 1 set.
- R4: Pass two always follows pass one. It writes 0 and then 0x200 to control and polls the same way with at most 1000 reads. The results go to p2_timeout and p2_lock.
- R5: When pass two completes with status bit 1 clear, step_size equals status bits [11:2]. Otherwise the step size starts at zero.
- R6: When the step size is zero, step_size = ((1000000 mod ddr_mhz) × 0x4EC4EC4F) >> 22, using a 64-bit product. A ddr_mhz of zero gives a remainder of zero.
- R7: The channel status register (0x2854) is read after the step size is settled. When its bit 1 is clear, the fine code (channel status bits [13:8] OR 0x10100) is written to the fine override register (0x2834) and shown on fine_code.
- R8: Let t = (step_size >> 4) × 3. The coarse code is 0x10000 OR (((t + 118) >> 1) AND 0x3F) when t > 10, and 0x10000 otherwise. It is written to the coarse override register (0x2830) after the fine write and shown on coarse_code.
- R9: When channel status bit 1 is set, no override register is written, ovr_skip is set and both codes stay zero.
- R10: done is high for exactly one cycle at the end of a run. The step size, codes and flags hold their values from then until the next accepted start.
- R11: A start pulse while busy is high is ignored. The running sequence makes no extra bus writes and produces a single done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse that begins a calibration run when idle |
| tick_us | input | 1 | One-cycle pulse every microsecond, paces polling |
| ddr_mhz | input | 16 | Configured DDR clock in MHz, used for the fallback step |
| bus_addr | output | 16 | Register address of the current request |
| bus_wdata | output | 32 | Write data of the current request |
| bus_wr | output | 1 | Write request, held until bus_ready |
| bus_rd | output | 1 | Read request, held until bus_ready |
| bus_ready | input | 1 | Completes the pending request |
| bus_rdata | input | 32 | Read data, valid with bus_ready |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| step_size | output | 32 | Final delay-line step size |
| fine_code | output | 32 | Fine override code that was written |
| coarse_code | output | 32 | Coarse override code that was written |
| p1_timeout | output | 1 | Pass one used all its polls without completing |
| p1_lock | output | 1 | Pass one completed with lock bit set |
| p2_timeout | output | 1 | Pass two used all its polls without completing |
| p2_lock | output | 1 | Pass two completed with lock bit set |
| ovr_skip | output | 1 | Override writes skipped because of channel status |

## Verification
Some properties are checked on every cycle by assertions: the one-strobe rule, stability of a request until ready, the single-cycle done pulse, hold of the results while idle, the shape of any coarse override write, and the absence of override writes once the skip flag is set. The bench scenarios are needed for the rest: the order and values of the control writes, the exact number of status reads in each pass at the poll limits, the field-versus-fallback choice for the step size with its divide-and-scale arithmetic, both sides of the coarse threshold, and a start pulse arriving mid-run.

// File: rtl/vdl_cal_seq.sv
module vdl_cal_seq #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int MHZ_W     = 16,
  parameter int P1_POLLS  = 100,
  parameter int P2_POLLS  = 1000,
  parameter logic [ADDR_W-1:0] A_COARSE = 16'h2830,
  parameter logic [ADDR_W-1:0] A_FINE   = 16'h2834,
  parameter logic [ADDR_W-1:0] A_CTL    = 16'h2848,
  parameter logic [ADDR_W-1:0] A_STAT   = 16'h284C,
  parameter logic [ADDR_W-1:0] A_CHAN   = 16'h2854,
  parameter logic [DATA_W-1:0] P1_GO    = 32'h103,
  parameter logic [DATA_W-1:0] P2_GO    = 32'h200,
  parameter int NUMER       = 1000000,
  parameter logic [63:0] RECIP_K = 64'h4EC4EC4F,
  parameter int RECIP_SH    = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              tick_us,
  input  logic [MHZ_W-1:0]  ddr_mhz,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_wr,
  output logic              bus_rd,
  input  logic              bus_ready,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] step_size,
  output logic [DATA_W-1:0] fine_code,
  output logic [DATA_W-1:0] coarse_code,
  output logic              p1_timeout,
  output logic              p1_lock,
  output logic              p2_timeout,
  output logic              p2_lock,
  output logic              ovr_skip
);

  localparam int POLL_W = $clog2(P2_POLLS + 1);
  localparam int NUM_W  = $clog2(NUMER + 1);
  localparam int CNT_W  = $clog2(NUM_W + 1);
  localparam logic [NUM_W-1:0] NUM_V = NUM_W'(NUMER);
  localparam logic [DATA_W-1:0] OVR_EN = DATA_W'(32'h10000);
  localparam logic [DATA_W-1:0] FINE_EN = DATA_W'(32'h10100);

  typedef enum logic [3:0] {
    S_IDLE, S_CLR, S_GO, S_POLL, S_WAIT, S_STEP, S_DIV, S_MUL,
    S_CHAN, S_WFINE, S_WCOARSE, S_FIN
  } state_t;

  state_t st;
  logic              pass2;
  logic [POLL_W-1:0] poll_cnt;
  logic [MHZ_W:0]    rem;
  logic [NUM_W-1:0]  dvd;
  logic [CNT_W-1:0]  div_cnt;
  logic [MHZ_W-1:0]  div_d;

  logic [POLL_W-1:0] poll_last;
  logic [MHZ_W:0]    trial;
  logic [63:0]       prod;
  logic [DATA_W-1:0] step_div16, t3, tsum, coarse_calc, fine_calc;
  logic              xfer;

  assign poll_last  = pass2 ? POLL_W'(P2_POLLS - 1) : POLL_W'(P1_POLLS - 1);
  assign trial      = {rem[MHZ_W-1:0], dvd[NUM_W-1]};
  assign prod       = 64'(rem) * RECIP_K;
  assign step_div16 = step_size >> 4;
  assign t3         = step_div16 + (step_div16 << 1);
  assign tsum       = t3 + DATA_W'(118);
  assign coarse_calc = (t3 > DATA_W'(10)) ? (OVR_EN | DATA_W'(tsum[6:1])) : OVR_EN;
  assign fine_calc  = FINE_EN | DATA_W'(bus_rdata[13:8]);
  assign xfer       = (bus_wr || bus_rd) && bus_ready;

  assign busy = (st != S_IDLE);
  assign done = (st == S_FIN);
  assign bus_wr = (st == S_CLR) || (st == S_GO) || (st == S_WFINE) || (st == S_WCOARSE);
  assign bus_rd = (st == S_POLL) || (st == S_CHAN);

  always_comb begin
    bus_addr  = '0;
    bus_wdata = '0;
    case (st)
      S_CLR:     bus_addr = A_CTL;
      S_GO:      begin bus_addr = A_CTL; bus_wdata = pass2 ? P2_GO : P1_GO; end
      S_POLL:    bus_addr = A_STAT;
      S_CHAN:    bus_addr = A_CHAN;
      S_WFINE:   begin bus_addr = A_FINE; bus_wdata = fine_code; end
      S_WCOARSE: begin bus_addr = A_COARSE; bus_wdata = coarse_code; end
      default:   ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      pass2 <= 1'b0;
      poll_cnt <= '0;
      rem <= '0;
      dvd <= '0;
      div_cnt <= '0;
      div_d <= '0;
      step_size <= '0;
      fine_code <= '0;
      coarse_code <= '0;
      p1_timeout <= 1'b0;
      p1_lock <= 1'b0;
      p2_timeout <= 1'b0;
      p2_lock <= 1'b0;
      ovr_skip <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st <= S_CLR;
          pass2 <= 1'b0;
          step_size <= '0;
          fine_code <= '0;
          coarse_code <= '0;
          p1_timeout <= 1'b0;
          p1_lock <= 1'b0;
          p2_timeout <= 1'b0;
          p2_lock <= 1'b0;
          ovr_skip <= 1'b0;
        end
        S_CLR: if (xfer) st <= S_GO;
        S_GO: if (xfer) begin
          st <= S_POLL;
          poll_cnt <= '0;
        end
        S_POLL: if (xfer) begin
          if (bus_rdata[0] || poll_cnt == poll_last) begin
            if (!pass2) begin
              p1_lock <= bus_rdata[0] & bus_rdata[1];
              p1_timeout <= ~bus_rdata[0];
              pass2 <= 1'b1;
              st <= S_CLR;
            end else begin
              p2_lock <= bus_rdata[0] & bus_rdata[1];
              p2_timeout <= ~bus_rdata[0];
              if (bus_rdata[0] && !bus_rdata[1])
                step_size <= DATA_W'(bus_rdata[11:2]);
              st <= S_STEP;
            end
          end else begin
            poll_cnt <= poll_cnt + 1'b1;
            st <= S_WAIT;
          end
        end
        S_WAIT: if (tick_us) st <= S_POLL;
        S_STEP: begin
          rem <= '0;
          dvd <= NUM_V;
          div_d <= ddr_mhz;
          div_cnt <= CNT_W'(NUM_W);
          if (step_size != '0)
            st <= S_CHAN;
          else if (ddr_mhz == '0)
            st <= S_MUL;
          else
            st <= S_DIV;
        end
        S_DIV: begin
          rem <= (trial >= {1'b0, div_d}) ? trial - {1'b0, div_d} : trial;
          dvd <= dvd << 1;
          div_cnt <= div_cnt - 1'b1;
          if (div_cnt == CNT_W'(1)) st <= S_MUL;
        end
        S_MUL: begin
          step_size <= DATA_W'(prod >> RECIP_SH);
          st <= S_CHAN;
        end
        S_CHAN: if (xfer) begin
          if (bus_rdata[1]) begin
            ovr_skip <= 1'b1;
            st <= S_FIN;
          end else begin
            fine_code <= fine_calc;
            st <= S_WFINE;
          end
        end
        S_WFINE: if (xfer) begin
          coarse_code <= coarse_calc;
          st <= S_WCOARSE;
        end
        S_WCOARSE: if (xfer) st <= S_FIN;
        S_FIN: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R2: one strobe at a time
  p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_rd));

  // R2: a waiting request keeps its address, data and kind
  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_wr || bus_rd) && !bus_ready) |=>
      ($stable(bus_addr) && $stable(bus_wdata) && $stable(bus_wr) && $stable(bus_rd)));

  // R10: done lasts one cycle
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: results hold while idle and not restarted
  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=>
      ($stable(step_size) && $stable(fine_code) && $stable(coarse_code) && $stable(ovr_skip)));

  // R8: coarse write always carries the enable bit and a 6-bit code
  p_coarse_shape_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_COARSE) |->
      (bus_wdata[16] && bus_wdata[15:6] == '0 && bus_wdata[DATA_W-1:17] == '0));

  // R9: no override writes once skipped
  p_no_ovr_skip_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ovr_skip) |-> !(bus_wr && (bus_addr == A_FINE || bus_addr == A_COARSE)));

  // R3 R4: poll counter stays inside the pass budget
  p_poll_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_POLL) |-> (poll_cnt <= poll_last));

endmodule

// File: tb/test_vdl_cal_seq.sv
module test_vdl_cal_seq;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV = 4;
  localparam logic [15:0] A_COARSE = 16'h2830, A_FINE = 16'h2834, A_CTL = 16'h2848,
                          A_STAT = 16'h284C, A_CHAN = 16'h2854;

  logic clk = 0, rst_n = 0, start = 0, tick_us = 0, bus_ready = 0;
  logic [15:0] ddr_mhz = 16'd450;
  logic [15:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic bus_wr, bus_rd, busy, done;
  logic [31:0] step_size, fine_code, coarse_code;
  logic p1_timeout, p1_lock, p2_timeout, p2_lock, ovr_skip;

  vdl_cal_seq i_vdl_cal_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .tick_us(tick_us), .ddr_mhz(ddr_mhz),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_ready(bus_ready), .bus_rdata(bus_rdata), .busy(busy), .done(done),
    .step_size(step_size), .fine_code(fine_code), .coarse_code(coarse_code),
    .p1_timeout(p1_timeout), .p1_lock(p1_lock), .p2_timeout(p2_timeout),
    .p2_lock(p2_lock), .ovr_skip(ovr_skip));

  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0, fails = 0, cyc = 0, tick_cnt = 0;
  int n1, n2, rc1, rc2, cur_pass, nw, n_done, proto_err, chan_reads;
  logic [31:0] s1, s2, chan;
  logic [15:0] wa [8];
  logic [31:0] wd [8];
  logic pend; logic [15:0] pa; logic [31:0] pd; logic pw, pr;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_STAT) begin
      if (cur_pass == 1 && n1 != 0 && rc1 + 1 >= n1) bus_rdata = s1;
      if (cur_pass == 2 && n2 != 0 && rc2 + 1 >= n2) bus_rdata = s2;
    end else if (bus_addr == A_CHAN) bus_rdata = chan;
  end

  always @(posedge clk) begin
    cyc++;
    tick_cnt = (tick_cnt + 1) % TICK_DIV;
    tick_us <= (tick_cnt == 0);
    if (!rst_n) bus_ready <= 0;
    else bus_ready <= (bus_wr || bus_rd) && !bus_ready;
    if (bus_wr && bus_rd) proto_err++;
    if (pend && (bus_addr != pa || bus_wdata != pd || bus_wr != pw || bus_rd != pr)) proto_err++;
    pend = (bus_wr || bus_rd) && !bus_ready;
    pa = bus_addr; pd = bus_wdata; pw = bus_wr; pr = bus_rd;
    if (bus_ready && bus_wr) begin
      if (nw < 8) begin wa[nw] = bus_addr; wd[nw] = bus_wdata; end
      nw++;
      if (bus_addr == A_CTL && bus_wdata == 32'h103) cur_pass = 1;
      if (bus_addr == A_CTL && bus_wdata == 32'h200) cur_pass = 2;
    end
    if (bus_ready && bus_rd && bus_addr == A_STAT) begin
      if (cur_pass == 1) rc1++; else if (cur_pass == 2) rc2++;
    end
    if (bus_ready && bus_rd && bus_addr == A_CHAN) chan_reads++;
    if (done) n_done++;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] dflt(input int unsigned mhz);
    longint unsigned r = (mhz == 0) ? 0 : (64'd1000000 % 64'(mhz));
    return 32'((r * 64'h4EC4EC4F) >> 22);
  endfunction

  function automatic logic [31:0] coarse_of(input logic [31:0] s);
    int unsigned t = (s >> 4) * 3;
    return (t > 10) ? (32'h10000 | (((t + 118) >> 1) & 32'h3F)) : 32'h10000;
  endfunction

  task automatic run(input int p1n, input logic [31:0] p1s, input int p2n,
                     input logic [31:0] p2s, input logic [31:0] ch, input logic [15:0] mhz,
                     input bit restart_mid);
    n1 = p1n; s1 = p1s; n2 = p2n; s2 = p2s; chan = ch; ddr_mhz = mhz;
    rc1 = 0; rc2 = 0; cur_pass = 0; nw = 0; n_done = 0; proto_err = 0; chan_reads = 0;
    @(negedge clk); start = 1; @(negedge clk); start = 0;
    for (int k = 0; k < 20000 && !done; k++) begin
      if (restart_mid && k == 40) start = 1; else start = 0;
      @(negedge clk);
    end
    start = 0;
    check(done === 1'b1, "R10 done seen", done, 1);
    @(negedge clk);
    check(done === 1'b0, "R10 done one cycle", done, 0);
    check(proto_err == 0, "R2 handshake", proto_err, 0);
  endtask

  task automatic check_ctl;
    check(wa[0] == A_CTL && wd[0] == 0, "R3 clear ctl", wd[0], 0);
    check(wa[1] == A_CTL && wd[1] == 32'h103, "R3 go ctl", wd[1], 32'h103);
    check(wa[2] == A_CTL && wd[2] == 0, "R4 clear ctl", wd[2], 0);
    check(wa[3] == A_CTL && wd[3] == 32'h200, "R4 go ctl", wd[3], 32'h200);
  endtask

  task automatic t_reset;
    rst_n = 0; repeat (3) @(negedge clk); 
    check(!bus_wr && !bus_rd && !done && !busy, "R1 idle strobes", {bus_wr, bus_rd, done, busy}, 0);
    check(step_size == 0 && fine_code == 0 && coarse_code == 0, "R1 outputs zero", step_size, 0);
    check({p1_timeout, p1_lock, p2_timeout, p2_lock, ovr_skip} == 0, "R1 flags zero",
          {p1_timeout, p1_lock, p2_timeout, p2_lock, ovr_skip}, 0);
    rst_n = 1; @(negedge clk);
  endtask

  task automatic t_normal;
    logic [31:0] st, fc, cc;
    run(3, 32'h3, 2, (32'h155 << 2) | 32'h1, 32'h2A00, 16'd450, 0);
    st = 32'h155; fc = 32'h1012A; cc = coarse_of(st);
    check_ctl();
    check(rc1 == 3, "R3 pass1 reads", rc1, 3);
    check(rc2 == 2, "R4 pass2 reads", rc2, 2);
    check(p1_lock && !p1_timeout, "R3 lock flag", {p1_lock, p1_timeout}, 2);
    check(!p2_lock && !p2_timeout, "R4 flags", {p2_lock, p2_timeout}, 0);
    check(step_size == st, "R5 field step", step_size, st);
    check(chan_reads == 1, "R7 chan read", chan_reads, 1);
    check(nw == 6 && wa[4] == A_FINE && wd[4] == fc, "R7 fine write", wd[4], fc);
    check(fine_code == fc, "R7 fine port", fine_code, fc);
    check(wa[5] == A_COARSE && wd[5] == cc && coarse_code == cc, "R8 coarse write", wd[5], cc);
    check(cc == 32'h1001A, "R8 coarse value", cc, 32'h1001A);
    repeat (40) @(negedge clk);
    check(step_size == st && fine_code == fc && coarse_code == cc && p1_lock, "R10 hold",
          step_size, st);
  endtask

  task automatic t_p1_timeout_restart;
    logic [31:0] ex;
    run(0, 0, 1, 32'h3, 32'h0500, 16'd450, 1);
    ex = dflt(450);
    check(rc1 == 100, "R3 pass1 limit", rc1, 100);
    check(p1_timeout && !p1_lock, "R3 timeout flag", {p1_timeout, p1_lock}, 2);
    check(p2_lock, "R4 lock flag", p2_lock, 1);
    check(step_size == ex && ex == 32'd31507, "R6 default step", step_size, ex);
    check(nw == 6 && n_done == 1, "R11 start ignored", nw, 6);
    check(fine_code == 32'h10105 && coarse_code == coarse_of(ex), "R8 codes", coarse_code, coarse_of(ex));
  endtask

  task automatic t_p2_timeout_skip;
    logic [31:0] ex;
    run(1, 32'h1, 0, 0, 32'h0002, 16'd533, 0);
    ex = dflt(533);
    check(rc2 == 1000, "R4 pass2 limit", rc2, 1000);
    check(p2_timeout && !p2_lock && !p1_lock, "R4 timeout flag", {p2_timeout, p2_lock}, 2);
    check(step_size == ex, "R6 default step 533", step_size, ex);
    check(nw == 4, "R9 no override writes", nw, 4);
    check(ovr_skip && fine_code == 0 && coarse_code == 0, "R9 skip flag", ovr_skip, 1);
  endtask

  task automatic t_small_step;
    run(1, 32'h1, 1, (32'd48 << 2) | 32'h1, 32'h0, 16'd450, 0);
    check(step_size == 48, "R5 small field", step_size, 48);
    check(coarse_code == 32'h10000 && wd[5] == 32'h10000, "R8 low threshold", coarse_code, 32'h10000);
    check(fine_code == 32'h10100, "R7 fine zero chan", fine_code, 32'h10100);
  endtask

  task automatic t_zero_speed;
    run(1, 32'h1, 1, 32'h1, 32'h0, 16'd0, 0);
    check(step_size == 0, "R6 zero speed", step_size, 0);
    check(coarse_code == 32'h10000, "R8 zero step coarse", coarse_code, 32'h10000);
  endtask

  task automatic t_field_zero_default;
    run(1, 32'h1, 1, 32'h1, 32'h0, 16'd400, 0);
    check(step_size == dflt(400), "R5 field zero uses default", step_size, dflt(400));
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_normal();
        t_p1_timeout_restart();
        t_p2_timeout_skip();
        t_small_step();
        t_zero_speed();
        t_field_zero_default();
      end
      begin
        wait (cyc > 150000);
        tests++; fails++;
        $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule